// File: doc/BRIEF.md
# Serial Logic-Analyzer Command Decoder

This block sits between a UART receiver and the control side of a logic-analyzer capture core. It takes the received byte stream and splits it into commands of two lengths. A byte with bit 7 clear is a complete command on its own. A byte with bit 7 set is an opcode that takes four more payload bytes. The decoded commands drive a set of configuration registers: a sample-clock divider, a capture size, a flag word, and a mask, a match value and a config word for every trigger stage. They also drive two one-cycle strobes, one for reset and one for run, and a four-byte identification reply sent to a UART transmitter through a valid/ready handshake.

The parser is a two-state machine. In ST_IDLE, a byte with bit 7 clear is decoded at once and the machine stays in ST_IDLE. A byte with bit 7 set takes the transition IDLE_TO_PAYLOAD, which latches the opcode. In ST_PAYLOAD every accepted byte is shifted in. The fourth byte takes the transition PAYLOAD_TO_IDLE and issues a single-cycle register write. The reply sequencer is also a two-state machine. ST_QUIET moves to ST_SEND (transition QUIET_TO_SEND) on an identify command. It moves back (transition SEND_TO_QUIET) either after the last byte is accepted or when a reset strobe arrives.

A host with no knowledge of the parser position resynchronises by sending the reset byte five times. This works because a frame never holds more than four bytes after its opcode.

Top module: `la_cmd_decoder`

## Requirements
- R1: Byte 0x00 accepted in idle gives a one-cycle `rst_strobe` in the cycle after it is accepted. Byte 0x01 gives a one-cycle `run_strobe` in the same way.
- R2: An opcode with bit 7 set is followed by exactly four payload bytes, and the first byte received is the least significant. The target register keeps its old value until the fourth byte arrives. It takes the full new word one cycle after the fourth byte is accepted.
- R3: Opcode 0x80 writes `divider`, so the sample period is divider+1 core clocks. Opcode 0x82 writes `flags`.
- R4: Opcode 0x81 writes the capture size. Payload bits 31:16 appear on `read_cnt_m1` (read count minus one) and bits 15:0 appear on `delay_cnt_m1` (delay count minus one). Both counts are in groups of four samples.
- R5: Opcode 0xC0 + 4*stage + field writes trigger stage `stage` (0 to 3). Field 0 is the mask, 1 is the value and 2 is the config. Stage s occupies bits [32*s+31 : 32*s] of `trig_mask`, `trig_value` and `trig_cfg`.
- R6: An opcode with bit 7 set that is not in the map (0x83 to 0xBF, 0xC3/0xC7/0xCB/0xCF, 0xD0 to 0xFF) still consumes four payload bytes and changes no register. Single bytes 0x03 to 0x7F give no strobe and no reply.
- R7: Payload bytes are never decoded as commands, even when their values are 0x00, 0x01 or 0x02.
- R8: Byte 0x02 in idle makes the block send 0x31, 0x53, 0x4C, 0x4F ("1SLO") in that order on `tx_data`. Each byte is held with `tx_valid` high until `tx_ready` is seen.
- R9: An identify command received while a reply is in progress is ignored. The reply in progress still sends exactly four bytes.
- R10: A reset strobe clears every configuration register to zero and drops any reply in progress. `tx_valid` is low in the cycle after the strobe.
- R11: Suppose k payload bytes (0 to 3) of a frame have been received when five 0x00 bytes arrive. Exactly k+1 reset strobes follow, and the next command is decoded normally.
- R12: After `rst_n` is released, all registers are zero, both strobes are low and `tx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter accepts `tx_data` this cycle |
| tx_valid | output | 1 | Reply byte present |
| tx_data | output | 8 | Reply byte |
| rst_strobe | output | 1 | One-cycle reset command pulse |
| run_strobe | output | 1 | One-cycle run command pulse |
| divider | output | 32 | Sample divider register |
| flags | output | 32 | Flag register |
| read_cnt_m1 | output | 16 | Read count minus one |
| delay_cnt_m1 | output | 16 | Delay count minus one |
| trig_mask | output | NSTAGE*32 | Trigger masks, stage 0 in the low word |
| trig_value | output | NSTAGE*32 | Trigger match values |
| trig_cfg | output | NSTAGE*32 | Trigger config words |

## Verification
The bench sweeps every unmapped opcode with bit 7 set, and every unused single byte as well. A decoder that treated an unmapped code as a one-byte command would lose frame alignment and pick up payload bytes as fresh opcodes. It then feeds five reset bytes into a frame cut off after each possible payload count and checks the exact number of reset strobes. A parser that restarted on every 0x00, or that counted payload bytes wrongly, would give a different count. The reply is stalled with a second identify sent during the stall, then aborted by a reset. A sequencer that restarted on the second identify would send extra bytes, and one that ignored the reset would keep `tx_valid` high.

// File: rtl/la_cmd_pkg.sv
package la_cmd_pkg;

    localparam logic [7:0] OP_RESET     = 8'h00;
    localparam logic [7:0] OP_RUN       = 8'h01;
    localparam logic [7:0] OP_IDENT     = 8'h02;
    localparam logic [7:0] OP_DIVIDER   = 8'h80;
    localparam logic [7:0] OP_CAPTURE   = 8'h81;
    localparam logic [7:0] OP_FLAGS     = 8'h82;

    localparam int REPLY_LEN = 4;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PAYLOAD = 1'b1
    } parse_state_t;

    typedef enum logic [0:0] {
        ST_QUIET = 1'b0,
        ST_SEND  = 1'b1
    } reply_state_t;

    function automatic logic [7:0] ident_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    return 8'h31;
            2'd1:    return 8'h53;
            2'd2:    return 8'h4C;
            default: return 8'h4F;
        endcase
    endfunction

endpackage

// File: rtl/la_cmd_parser.sv
module la_cmd_parser
    import la_cmd_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rst_pulse,
    output logic              run_pulse,
    output logic              ident_pulse,
    output logic              wr_en,
    output logic [7:0]        wr_addr,
    output logic [WORD_W-1:0] wr_data
);

    localparam int NBYTES = WORD_W / 8;
    localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NBYTES - 1);

    parse_state_t      state;
    logic [CNT_W-1:0]  byte_cnt;
    logic [7:0]        opcode_q;
    logic [WORD_W-1:0] shift_q;
    logic [WORD_W-1:0] shift_next;
    logic              last_byte;

    assign shift_next = {rx_data, shift_q[WORD_W-1:8]};
    assign last_byte  = (byte_cnt == LAST_IDX);

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            byte_cnt <= '0;
            opcode_q <= '0;
            shift_q  <= '0;
        end else if (rx_valid) begin
            unique case (state)
                ST_IDLE: begin
                    if (rx_data[7]) begin
                        state    <= ST_PAYLOAD;
                        opcode_q <= rx_data;
                        byte_cnt <= '0;
                    end
                end
                ST_PAYLOAD: begin
                    shift_q <= shift_next;
                    if (last_byte) begin
                        state    <= ST_IDLE;
                        byte_cnt <= '0;
                    end else begin
                        byte_cnt <= byte_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Registered command outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_pulse   <= 1'b0;
            run_pulse   <= 1'b0;
            ident_pulse <= 1'b0;
            wr_en       <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
        end else begin
            rst_pulse   <= 1'b0;
            run_pulse   <= 1'b0;
            ident_pulse <= 1'b0;
            wr_en       <= 1'b0;
            if (rx_valid) begin
                unique case (state)
                    ST_IDLE: begin
                        rst_pulse   <= (rx_data == OP_RESET);
                        run_pulse   <= (rx_data == OP_RUN);
                        ident_pulse <= (rx_data == OP_IDENT);
                    end
                    ST_PAYLOAD: begin
                        if (last_byte) begin
                            wr_en   <= 1'b1;
                            wr_addr <= opcode_q;
                            wr_data <= shift_next;
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/la_cmd_regs.sv
module la_cmd_regs
    import la_cmd_pkg::*;
#(
    parameter int NSTAGE = 4,
    parameter int WORD_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr_en,
    input  logic [7:0]               wr_addr,
    input  logic [WORD_W-1:0]        wr_data,
    output logic [WORD_W-1:0]        divider,
    output logic [WORD_W-1:0]        flags,
    output logic [WORD_W/2-1:0]      read_cnt_m1,
    output logic [WORD_W/2-1:0]      delay_cnt_m1,
    output logic [NSTAGE*WORD_W-1:0] trig_mask,
    output logic [NSTAGE*WORD_W-1:0] trig_value,
    output logic [NSTAGE*WORD_W-1:0] trig_cfg
);

    localparam int HALF_W = WORD_W / 2;
    localparam int STG_W  = 4;

    logic [WORD_W-1:0] div_q, flg_q, cap_q;
    logic [WORD_W-1:0] mask_q  [NSTAGE];
    logic [WORD_W-1:0] value_q [NSTAGE];
    logic [WORD_W-1:0] cfg_q   [NSTAGE];

    logic             is_trig;
    logic [STG_W-1:0] stage_sel;
    logic [1:0]       field_sel;

    assign is_trig   = (wr_addr[7:6] == 2'b11);
    assign stage_sel = wr_addr[5:2];
    assign field_sel = wr_addr[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            flg_q <= '0;
            cap_q <= '0;
            for (int s = 0; s < NSTAGE; s++) begin
                mask_q[s]  <= '0;
                value_q[s] <= '0;
                cfg_q[s]   <= '0;
            end
        end else if (clr) begin
            div_q <= '0;
            flg_q <= '0;
            cap_q <= '0;
            for (int s = 0; s < NSTAGE; s++) begin
                mask_q[s]  <= '0;
                value_q[s] <= '0;
                cfg_q[s]   <= '0;
            end
        end else if (wr_en) begin
            if (wr_addr == OP_DIVIDER) div_q <= wr_data;
            if (wr_addr == OP_CAPTURE) cap_q <= wr_data;
            if (wr_addr == OP_FLAGS)   flg_q <= wr_data;
            for (int s = 0; s < NSTAGE; s++) begin
                if (is_trig && stage_sel == STG_W'(s)) begin
                    if (field_sel == 2'd0) mask_q[s]  <= wr_data;
                    if (field_sel == 2'd1) value_q[s] <= wr_data;
                    if (field_sel == 2'd2) cfg_q[s]   <= wr_data;
                end
            end
        end
    end

    assign divider      = div_q;
    assign flags        = flg_q;
    assign read_cnt_m1  = cap_q[WORD_W-1:HALF_W];
    assign delay_cnt_m1 = cap_q[HALF_W-1:0];

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        assign trig_mask [g*WORD_W +: WORD_W] = mask_q[g];
        assign trig_value[g*WORD_W +: WORD_W] = value_q[g];
        assign trig_cfg  [g*WORD_W +: WORD_W] = cfg_q[g];
    end

endmodule

// File: rtl/la_cmd_reply.sv
module la_cmd_reply
    import la_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       abort,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data
);

    reply_state_t state;
    logic [1:0]   idx;
    logic         accept;

    assign accept = (state == ST_SEND) && tx_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_QUIET;
            idx   <= '0;
        end else if (abort) begin
            state <= ST_QUIET;
            idx   <= '0;
        end else begin
            unique case (state)
                ST_QUIET: begin
                    if (start) begin
                        state <= ST_SEND;
                        idx   <= '0;
                    end
                end
                ST_SEND: begin
                    if (accept) begin
                        if (idx == 2'(REPLY_LEN - 1)) begin
                            state <= ST_QUIET;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        tx_valid = (state == ST_SEND);
        tx_data  = ident_byte(idx);
    end

endmodule

// File: rtl/la_cmd_decoder.sv
module la_cmd_decoder
    import la_cmd_pkg::*;
#(
    parameter int NSTAGE = 4,
    parameter int WORD_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rx_valid,
    input  logic [7:0]               rx_data,
    input  logic                     tx_ready,
    output logic                     tx_valid,
    output logic [7:0]               tx_data,
    output logic                     rst_strobe,
    output logic                     run_strobe,
    output logic [WORD_W-1:0]        divider,
    output logic [WORD_W-1:0]        flags,
    output logic [WORD_W/2-1:0]      read_cnt_m1,
    output logic [WORD_W/2-1:0]      delay_cnt_m1,
    output logic [NSTAGE*WORD_W-1:0] trig_mask,
    output logic [NSTAGE*WORD_W-1:0] trig_value,
    output logic [NSTAGE*WORD_W-1:0] trig_cfg
);

    logic              ident_pulse;
    logic              wr_en;
    logic [7:0]        wr_addr;
    logic [WORD_W-1:0] wr_data;

    la_cmd_parser #(.WORD_W(WORD_W)) u_parser (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rst_pulse   (rst_strobe),
        .run_pulse   (run_strobe),
        .ident_pulse (ident_pulse),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data)
    );

    la_cmd_regs #(.NSTAGE(NSTAGE), .WORD_W(WORD_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (rst_strobe),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .divider      (divider),
        .flags        (flags),
        .read_cnt_m1  (read_cnt_m1),
        .delay_cnt_m1 (delay_cnt_m1),
        .trig_mask    (trig_mask),
        .trig_value   (trig_value),
        .trig_cfg     (trig_cfg)
    );

    la_cmd_reply u_reply (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (ident_pulse),
        .abort    (rst_strobe),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

endmodule

// File: rtl/la_cmd_chk.sv
module la_cmd_chk #(
    parameter int NSTAGE = 4,
    parameter int WORD_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     rst_strobe,
    input logic                     tx_valid,
    input logic                     tx_ready,
    input logic [7:0]               tx_data,
    input logic [WORD_W-1:0]        divider,
    input logic [WORD_W-1:0]        flags,
    input logic [WORD_W/2-1:0]      read_cnt_m1,
    input logic [WORD_W/2-1:0]      delay_cnt_m1,
    input logic [NSTAGE*WORD_W-1:0] trig_mask,
    input logic [NSTAGE*WORD_W-1:0] trig_value,
    input logic [NSTAGE*WORD_W-1:0] trig_cfg
);

    AST_CLEAR_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_strobe |=> (divider == '0 && flags == '0 && read_cnt_m1 == '0 &&
                        delay_cnt_m1 == '0 && trig_mask == '0 &&
                        trig_value == '0 && trig_cfg == '0)); // R10

    AST_ABORT_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_strobe |=> !tx_valid); // R10

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !rst_strobe) |=> (tx_valid && $stable(tx_data))); // R8

    AST_ORDER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_data == 8'h31 && !rst_strobe) |=>
        (tx_valid && tx_data == 8'h53)); // R8

    AST_ORDER_THIRD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_data == 8'h4C && !rst_strobe) |=>
        (tx_valid && tx_data == 8'h4F)); // R8

endmodule

bind la_cmd_decoder la_cmd_chk #(.NSTAGE(NSTAGE), .WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_strobe   (rst_strobe),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data),
    .divider      (divider),
    .flags        (flags),
    .read_cnt_m1  (read_cnt_m1),
    .delay_cnt_m1 (delay_cnt_m1),
    .trig_mask    (trig_mask),
    .trig_value   (trig_value),
    .trig_cfg     (trig_cfg)
);

// File: tb/la_cmd_decoder_tb.sv
module la_cmd_decoder_tb;

    localparam int NS = 4;
    localparam int W  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic tx_ready = 1'b1;
    logic tx_valid;
    logic [7:0] tx_data;
    logic rst_strobe, run_strobe;
    logic [W-1:0] divider, flags;
    logic [W/2-1:0] read_cnt_m1, delay_cnt_m1;
    logic [NS*W-1:0] trig_mask, trig_value, trig_cfg;

    always #5 clk = ~clk;

    la_cmd_decoder #(.NSTAGE(NS), .WORD_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .rst_strobe(rst_strobe), .run_strobe(run_strobe),
        .divider(divider), .flags(flags),
        .read_cnt_m1(read_cnt_m1), .delay_cnt_m1(delay_cnt_m1),
        .trig_mask(trig_mask), .trig_value(trig_value), .trig_cfg(trig_cfg)
    );

    int n_checks = 0;
    int n_bad = 0;
    int n_rst = 0;
    int n_run = 0;
    int n_tx = 0;
    logic [7:0] got [0:63];
    bit done = 0;

    logic [W-1:0] e_div, e_flg, e_cap;
    logic [W-1:0] e_mask [NS];
    logic [W-1:0] e_val  [NS];
    logic [W-1:0] e_cfg  [NS];

    always @(posedge clk) begin
        if (rst_strobe) n_rst <= n_rst + 1;
        if (run_strobe) n_run <= n_run + 1;
        if (tx_valid && tx_ready) begin
            got[n_tx[5:0]] <= tx_data;
            n_tx <= n_tx + 1;
        end
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        e_div = '0; e_flg = '0; e_cap = '0;
        for (int s = 0; s < NS; s++) begin
            e_mask[s] = '0; e_val[s] = '0; e_cfg[s] = '0;
        end
    endtask

    task automatic chk_regs(input string req);
        chk({req, " divider"}, divider, e_div);
        chk({req, " flags"}, flags, e_flg);
        chk({req, " read"}, W'(read_cnt_m1), W'(e_cap[31:16]));
        chk({req, " delay"}, W'(delay_cnt_m1), W'(e_cap[15:0]));
        for (int s = 0; s < NS; s++) begin
            chk({req, " mask"},  trig_mask [s*W +: W], e_mask[s]);
            chk({req, " value"}, trig_value[s*W +: W], e_val[s]);
            chk({req, " cfg"},   trig_cfg  [s*W +: W], e_cfg[s]);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_long(input logic [7:0] op, input logic [W-1:0] v);
        send_byte(op);
        for (int i = 0; i < 4; i++) send_byte(v[i*8 +: 8]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        int base_rst, base_run, base_tx;
        model_clear();
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R12 reset state
        chk_regs("R12");
        chk("R12 tx_valid", W'(tx_valid), 0);
        chk("R12 strobes", W'(n_rst + n_run), 0);

        // R3 divider write
        send_long(8'h80, 32'h1234_5678); e_div = 32'h1234_5678;
        idle(2);
        chk_regs("R3");

        // R2 partial frame holds old value, then updates
        send_byte(8'h82);
        send_byte(8'hEF); send_byte(8'hBE); send_byte(8'hAD);
        idle(3);
        chk("R2 before fourth byte", flags, 32'h0);
        send_byte(8'hDE);
        chk("R2 not yet after accept", flags, 32'h0);
        @(negedge clk);
        chk("R2 lsb-first word", flags, 32'hDEAD_BEEF);
        e_flg = 32'hDEAD_BEEF;

        // R4 capture size split
        send_long(8'h81, 32'hABCD_0123); e_cap = 32'hABCD_0123;
        idle(2);
        chk_regs("R4");

        // R5 sweep over stages and fields
        for (int s = 0; s < NS; s++) begin
            for (int f = 0; f < 3; f++) begin
                logic [W-1:0] v;
                v = (32'h0102_0304 * (s*3 + f + 1)) ^ 32'hA5A5_0000;
                send_long(8'hC0 + 8'(4*s + f), v);
                if (f == 0) e_mask[s] = v;
                if (f == 1) e_val[s]  = v;
                if (f == 2) e_cfg[s]  = v;
            end
        end
        idle(2);
        chk_regs("R5");

        // R6 unmapped long opcodes
        base_rst = n_rst; base_run = n_run; base_tx = n_tx;
        for (int op = 8'h83; op <= 8'hFF; op++) begin
            if (!(op >= 8'hC0 && op <= 8'hCF && op[1:0] != 2'd3))
                send_long(8'(op), 32'hFFFF_FFFF);
        end
        idle(2);
        chk_regs("R6 long");
        // R6 unused single bytes
        for (int op = 8'h03; op <= 8'h7F; op++) send_byte(8'(op));
        idle(4);
        chk("R6 no strobes", W'((n_rst - base_rst) + (n_run - base_run)), 0);
        chk("R6 no reply", W'(n_tx - base_tx), 0);
        chk_regs("R6 short");

        // R7 command-like payload bytes
        send_long(8'h80, 32'h0002_0100); e_div = 32'h0002_0100;
        idle(10);
        chk("R7 no strobes", W'((n_rst - base_rst) + (n_run - base_run)), 0);
        chk("R7 no reply", W'(n_tx - base_tx), 0);
        chk_regs("R7");

        // R1 run strobe width
        send_byte(8'h01);
        chk("R1 run high", W'(run_strobe), 1);
        @(negedge clk);
        chk("R1 run one cycle", W'(run_strobe), 0);
        chk("R1 run count", W'(n_run - base_run), 1);

        // R1 and R10 reset strobe clears registers
        send_byte(8'h00);
        chk("R1 reset high", W'(rst_strobe), 1);
        @(negedge clk);
        chk("R1 reset one cycle", W'(rst_strobe), 0);
        model_clear();
        chk_regs("R10");

        // R8 plain identify
        base_tx = n_tx;
        send_byte(8'h02);
        idle(8);
        chk("R8 reply length", W'(n_tx - base_tx), 4);
        chk("R8 byte0", W'(got[base_tx + 0]), 32'h31);
        chk("R8 byte1", W'(got[base_tx + 1]), 32'h53);
        chk("R8 byte2", W'(got[base_tx + 2]), 32'h4C);
        chk("R8 byte3", W'(got[base_tx + 3]), 32'h4F);

        // R8 stall, R9 second identify ignored
        base_tx = n_tx;
        tx_ready = 1'b0;
        send_byte(8'h02);
        idle(3);
        chk("R8 stall valid", W'(tx_valid), 1);
        chk("R8 stall data", W'(tx_data), 32'h31);
        send_byte(8'h02);
        idle(2);
        tx_ready = 1'b1;
        idle(10);
        chk("R9 single reply", W'(n_tx - base_tx), 4);
        chk("R9 last byte", W'(got[base_tx + 3]), 32'h4F);
        chk("R9 quiet", W'(tx_valid), 0);

        // R10 reset aborts reply
        base_tx = n_tx;
        tx_ready = 1'b0;
        send_byte(8'h02);
        idle(2);
        send_byte(8'h00);
        @(negedge clk);
        chk("R10 abort", W'(tx_valid), 0);
        tx_ready = 1'b1;
        idle(5);
        chk("R10 nothing sent", W'(n_tx - base_tx), 0);

        // R11 resync from every position in a frame
        for (int k = 0; k < 4; k++) begin
            base_rst = n_rst;
            send_byte(8'h80);
            for (int i = 0; i < k; i++) send_byte(8'h5A + 8'(i));
            for (int i = 0; i < 5; i++) send_byte(8'h00);
            idle(3);
            chk("R11 reset count", W'(n_rst - base_rst), W'(k + 1));
            model_clear();
            chk_regs("R11 cleared");
            send_long(8'h82, 32'h0000_0100 + W'(k));
            idle(2);
            chk("R11 next command", flags, 32'h0000_0100 + W'(k));
            e_flg = 32'h0000_0100 + W'(k);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule